// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

A purely combinational 32-bit arithmetic and logic unit for the execute stage of a load/store integer core. It receives two operands, a shift distance and a 4-bit operation code, and returns in the same cycle a result word, a flag that is high when that word is zero, and a signed-overflow flag. It covers the following operations:

- add and subtract
- four bitwise operations, one of them NOR
- three shifts of operand A
- signed and unsigned set-less-than

Decoding, operand fetch, multiply and divide stay outside the block. One adder serves add, subtract and both comparisons. Subtraction is formed as A plus the inverted B plus one. A single right barrel shifter, wrapped in bit reversal, performs all three shifts.

Top module: `int_alu`

## Requirements
- R1: Code 0 (add) returns (A + B) mod 2^32; the carry out of bit 31 is dropped.
- R2: Code 1 (subtract) returns A + ~B + 1 mod 2^32, that is (A - B) mod 2^32.
- R3: For codes 0 and 1, ovf_o is 1 exactly when the true signed result lies outside -2^31..2^31-1. An add of operands with opposite signs never raises it, and a subtract of operands with equal signs never raises it.
- R4: For every code other than 0 and 1, ovf_o is 0.
- R5: Code 2 gives A AND B, code 3 gives A OR B, code 4 gives A XOR B.
- R6: Code 5 gives the bitwise inverse of (A OR B).
- R7: Code 6 shifts A left by shamt_i (0..31) and fills with zeros, so the result equals A * 2^shamt_i mod 2^32.
- R8: Code 7 shifts A right by shamt_i and fills the upper bits with zeros.
- R9: Code 8 shifts A right by shamt_i and fills the upper bits with bit 31 of A.
- R10: Code 9 returns 32'd1 when A < B as two's complement values, else 32'd0.
- R11: Code 10 returns 32'd1 when A < B as unsigned values, else 32'd0.
- R12: zero_o is 1 exactly when result_o is all zeros, for every code.
- R13: Codes 11 to 15 give result_o = 0, zero_o = 1 and ovf_o = 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, also the value shifted |
| b_i | input | 32 | Second operand |
| shamt_i | input | 5 | Shift distance |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is zero |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The checker samples immediately after every input change. It assumes that the four inputs are known 2-state values and that they settle together, so that no half-updated operand pair is ever judged. The stimulus meets this by changing all inputs at once on the falling bench clock edge, never in between, and by comparing the outputs only on the rising edge. The corner cases for overflow, for a zero shift distance, for a shift distance of 31 and for equal operands are driven as directed vectors. A random sweep then covers all sixteen codes.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOR  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SRA  = 4'd8,
    OP_SLT  = 4'd9,
    OP_SLTU = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  // sign rule on the effective operands
  assign ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import int_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] out_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  out_o = a_i & b_i;
      LG_OR:   out_o = a_i | b_i;
      LG_XOR:  out_o = a_i ^ b_i;
      default: out_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] amt_i,
  input  logic          right_i,
  input  logic          arith_i,
  output logic [W-1:0]  out_o
);
  logic [W-1:0] a_rev, res_rev, pre;
  logic [W-1:0] stg [SW+1];
  logic         fill;

  // left shift = reverse, shift right, reverse
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i]   = a_i[W-1-i];
    assign res_rev[i] = stg[SW][W-1-i];
  end

  assign pre    = right_i ? a_i : a_rev;
  assign fill   = right_i & arith_i & a_i[W-1];
  assign stg[0] = pre;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned S = 2 ** k;
    assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  assign out_o = right_i ? stg[SW] : res_rev;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] sum, lg_out, sh_out;
  logic             carry, ov_raw, sub_en, is_arith;
  logic             lt_s, lt_u, sh_right, sh_arith;
  logic_sel_e       lg_sel;

  assign sub_en   = (op_i != OP_ADD);
  assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign sh_right = (op_i == OP_SRL) || (op_i == OP_SRA);
  assign sh_arith = (op_i == OP_SRA);

  always_comb begin
    case (op_i)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      OP_NOR:  lg_sel = LG_NOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu_addsub #(.W(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_en),
    .sum_o(sum), .carry_o(carry), .ovf_o(ov_raw)
  );

  alu_logic #(.W(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(lg_sel), .out_o(lg_out)
  );

  alu_shift #(.W(WIDTH), .SW(SHW)) u_shift (
    .a_i(a_i), .amt_i(shamt_i), .right_i(sh_right),
    .arith_i(sh_arith), .out_o(sh_out)
  );

  // compare results from the subtract path
  assign lt_s = sum[WIDTH-1] ^ ov_raw;
  assign lt_u = ~carry;

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB:                 result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:  result_o = lg_out;
      OP_SLL, OP_SRL, OP_SRA:         result_o = sh_out;
      OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(WIDTH-1){1'b0}}, lt_u};
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
  assign ovf_o  = is_arith & ov_raw;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SHW   = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  always_comb begin
    if (op_i > 4'd1)
      AST_NO_OVERFLOW: assert (!ovf_o) else $error("ovf outside add/sub"); // R4
    if (op_i == 4'd0 && a_i[WIDTH-1] != b_i[WIDTH-1])
      AST_OPP_SIGN_ADD: assert (!ovf_o) else $error("ovf on mixed-sign add"); // R3
    if (op_i == 4'd1 && a_i == b_i)
      AST_SUB_SELF: assert (zero_o && !ovf_o) else $error("a-a not zero"); // R2
    if (op_i == 4'd6 && shamt_i != '0)
      AST_SLL_LSB: assert (!result_o[0]) else $error("sll lsb set"); // R7
    if (op_i == 4'd7 && shamt_i != '0)
      AST_SRL_MSB: assert (!result_o[WIDTH-1]) else $error("srl msb set"); // R8
    if (op_i == 4'd8)
      AST_SRA_SIGN: assert (result_o[WIDTH-1] == a_i[WIDTH-1]) else $error("sra sign lost"); // R9
    if (op_i == 4'd9 || op_i == 4'd10)
      AST_SLT_BOOL: assert (result_o[WIDTH-1:1] == '0) else $error("slt not boolean"); // R10 R11
    if (op_i > 4'd10)
      AST_UNUSED_CODE: assert (result_o == '0 && zero_o && !ovf_o) else $error("unused code"); // R13
  end
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH), .SHW(SHW)) chk_i (
  .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i), .op_i(op_i),
  .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
);

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic        zf, vf;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  int_alu dut_i (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
    .result_o(res), .zero_o(zf), .ovf_o(vf)
  );

  typedef struct {
    logic [31:0] a, b, r;
    logic [4:0]  sh;
    logic [3:0]  op;
    logic        z, v;
  } item_t;

  item_t q[$];
  item_t cur;

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      4'd10: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, item_t it);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h b=%h sh=%0d got %h expected %h",
               tag, it.op, it.a, it.b, it.sh, got, exp);
    end
  endtask

  // reference model
  task automatic drive(logic [31:0] xa, logic [31:0] xb, logic [4:0] xs, logic [3:0] xo);
    item_t  it;
    longint s;
    it.a = xa; it.b = xb; it.sh = xs; it.op = xo; it.v = 1'b0;
    case (xo)
      4'd0: begin
        it.r = xa + xb;
        s = longint'($signed(xa)) + longint'($signed(xb));
        it.v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'd1: begin
        it.r = xa - xb;
        s = longint'($signed(xa)) - longint'($signed(xb));
        it.v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'd2: it.r = xa & xb;
      4'd3: it.r = xa | xb;
      4'd4: it.r = xa ^ xb;
      4'd5: it.r = ~(xa | xb);
      4'd6: it.r = xa << xs;
      4'd7: it.r = xa >> xs;
      4'd8: it.r = $signed(xa) >>> xs;
      4'd9: it.r = {31'd0, $signed(xa) < $signed(xb)};
      4'd10: it.r = {31'd0, xa < xb};
      default: it.r = 32'd0;
    endcase
    it.z = (it.r == 32'd0);
    @(negedge clk);
    a = xa; b = xb; sh = xs; op = xo;
    q.push_back(it);
  endtask

  // monitor: outputs settled since the previous falling edge
  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      cur = q.pop_front();
      chk(tag_of(cur.op), res, cur.r, cur);
      chk("R12", {31'd0, zf}, {31'd0, cur.z}, cur);
      chk((cur.op <= 4'd1) ? "R3" : "R4", {31'd0, vf}, {31'd0, cur.v}, cur);
    end
  end

  initial begin
    a = '0; b = '0; sh = '0; op = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state with all-zero inputs: add of zeros
    checks++;
    if (res !== 32'd0 || zf !== 1'b1 || vf !== 1'b0) begin
      errors++;
      $display("FAIL R1: idle got %h/%b/%b expected 0/1/0", res, zf, vf);
    end
    rst_ni = 1'b1;

    // R1 / R3 add corners
    drive(32'h7fffffff, 32'h00000001, 0, 4'd0);
    drive(32'h80000000, 32'h80000000, 0, 4'd0);
    drive(32'h7fffffff, 32'hffffffff, 0, 4'd0);
    drive(32'hffffffff, 32'h00000001, 0, 4'd0);
    drive(32'h00000064, 32'h00000032, 0, 4'd0);
    // R2 / R3 subtract corners
    drive(32'h80000000, 32'h00000001, 0, 4'd1);
    drive(32'h7fffffff, 32'hffffffff, 0, 4'd1);
    drive(32'h00000000, 32'h80000000, 0, 4'd1);
    drive(32'h12345678, 32'h12345678, 0, 4'd1);
    drive(32'hffffffff, 32'hfffffffe, 0, 4'd1);
    // R5 R6 logic
    drive(32'hf0f0a5a5, 32'h0ff05a5a, 0, 4'd2);
    drive(32'hf0f0a5a5, 32'h0ff05a5a, 0, 4'd3);
    drive(32'hf0f0a5a5, 32'h0ff05a5a, 0, 4'd4);
    drive(32'h00000000, 32'h00000000, 0, 4'd5);
    drive(32'hffff0000, 32'h0000ffff, 0, 4'd5);
    // R7 R8 R9 shift distance edges
    for (int s = 0; s < 32; s += 31) begin
      drive(32'h80000001, 32'h0, s[4:0], 4'd6);
      drive(32'h80000001, 32'h0, s[4:0], 4'd7);
      drive(32'h80000001, 32'h0, s[4:0], 4'd8);
      drive(32'h40000000, 32'h0, s[4:0], 4'd8);
    end
    drive(32'h00000003, 32'h0, 5'd4, 4'd6);
    // R10 R11 signed versus unsigned
    drive(32'hffffffff, 32'h00000001, 0, 4'd9);
    drive(32'hffffffff, 32'h00000001, 0, 4'd10);
    drive(32'h80000000, 32'h7fffffff, 0, 4'd9);
    drive(32'h7fffffff, 32'h80000000, 0, 4'd9);
    drive(32'h00000005, 32'h00000005, 0, 4'd9);
    drive(32'h00000005, 32'h00000005, 0, 4'd10);
    drive(32'h00000000, 32'hffffffff, 0, 4'd10);
    // R13 unused codes
    for (int o = 11; o < 16; o++) drive(32'hdeadbeef, 32'hcafef00d, 5'd7, o[3:0]);

    // random sweep over all codes
    for (int n = 0; n < 300; n++) begin
      for (int o = 0; o < 16; o++) begin
        logic [31:0] ra, rb;
        ra = $urandom;
        rb = (n % 7 == 0) ? ra : $urandom;
        if (n % 5 == 0) ra[31:30] = rb[31:30];
        drive(ra, rb, 5'($urandom), o[3:0]);
      end
    end

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule